// File: doc/BRIEF.md
# Power-On Reset Boot Sequencer

This block brings a processor subsystem out of power-on reset. It takes a raw oscillator clock and a supply-good level from an external voltage monitor. It drives a system clock at a quarter of the oscillator rate. It also drives an active-low reset that stays low until the supply has been good for long enough. When reset lifts, the block makes two word reads on a small memory read port. The word at address 0x0 becomes the initial stack pointer. The word at address 0x4 becomes the initial program counter. A done flag then rises.

All sequencing logic runs on the oscillator clock. It advances once per system clock period, on the oscillator edge that makes the system clock rise, so every state change lines up with a system clock rising edge. Loss of supply resets the sequencer at once, without waiting for a clock edge, and the whole sequence starts again.

Top module: `por_boot_seq`

## Requirements
- R1: While `supply_ok` is low, `por_n_o`, `mem_req_o` and `boot_done_o` are 0, and `mem_addr_o`, `sp_o` and `pc_o` read 0.
- R2: `sys_clk_o` is the oscillator clock divided by 4 with a 50% duty cycle: high for 2 oscillator cycles, then low for 2. It keeps running whatever the state of `supply_ok`.
- R3: With `supply_ok` held high, `por_n_o` goes high on the 6th rising edge of `sys_clk_o` after `supply_ok` went high. That is 2 edges of synchronisation followed by 4 edges of stable supply.
- R4: On the same edge that raises `por_n_o`, `mem_req_o` rises with `mem_addr_o` = 0x0. After that read completes, the address becomes 0x4 and `mem_req_o` stays high. `mem_req_o` is never high while `por_n_o` is low.
- R5: A read completes on a rising edge of `sys_clk_o` where `mem_req_o` and `mem_ready_i` are both high, and `mem_rdata_i` is captured on that edge. The first word is stored in `sp_o` and the second in `pc_o`. On the second completion `boot_done_o` rises and `mem_req_o` falls, and both then hold.
- R6: While `mem_ready_i` is low, `mem_req_o` and `mem_addr_o` hold their values for as long as it stays low.
- R7: A fall of `supply_ok` at any point clears all outputs at once, before the next oscillator edge, except `sys_clk_o`. A later rise of `supply_ok` restarts the sequence from the beginning.
- R8: A supply-good pulse shorter than the release window does not release reset. Counting starts again from zero at the next rise.
- R9: If `supply_ok` falls in the same system cycle in which a read would complete, the reset wins: nothing is captured and `boot_done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock |
| supply_ok | input | 1 | Supply-good level from the monitor, asynchronous; low resets |
| sys_clk_o | output | 1 | Divided system clock |
| por_n_o | output | 1 | Active-low power-on reset |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | 32 | Read address |
| mem_ready_i | input | 1 | Read accepted, data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| sp_o | output | 32 | Initial stack pointer |
| pc_o | output | 32 | Initial program counter |
| boot_done_o | output | 1 | Both boot words loaded |

## Verification
Two events can land in the same system cycle: the asynchronous clear caused by a supply drop, and the completion of a read handshake. The bench waits until the second fetch is stalled with ready low. It then, within one oscillator cycle, raises ready and drops supply-good just before the system edge that would complete the read. It expects `pc_o` to stay 0 and `boot_done_o` to stay low. A second conflict, a supply pulse that ends inside the stability window, is judged by whether the release edge of the next attempt falls exactly 6 system edges after the final rise.

// File: rtl/por_boot_pkg.sv
package por_boot_pkg;
  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_SP   = 2'd1,
    BS_PC   = 2'd2,
    BS_DONE = 2'd3
  } boot_state_e;
endpackage

// File: rtl/por_clk_div.sv
module por_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  output logic sys_clk,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  // free-running: the divided clock must run during reset
  logic [CW-1:0] cnt_q = '0;

  always_ff @(posedge clk) begin
    cnt_q <= cnt_q + CW'(1);
  end

  assign sys_clk = cnt_q[CW-1];
  // true on the oscillator edge that raises sys_clk
  assign tick    = (cnt_q == CW'(DIV / 2 - 1));

  p_sysclk_phase_r2: assert property (@(posedge clk)
    $rose(sys_clk) |-> $past(tick));
endmodule

// File: rtl/por_release_filter.sv
module por_release_filter #(
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_TICKS = 4
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic tick,
  output logic released,
  output logic start
);
  localparam int SW = $clog2(STABLE_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SW-1:0]          stab_q;
  logic                   rel_q;
  logic                   good;

  assign good  = sync_q[SYNC_STAGES-1];
  assign start = tick && !rel_q && good && (stab_q == SW'(STABLE_TICKS - 1));

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      sync_q <= '0;
      stab_q <= '0;
      rel_q  <= 1'b0;
    end else if (tick) begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      if (start)
        rel_q <= 1'b1;
      else if (!rel_q && good)
        stab_q <= stab_q + SW'(1);
    end
  end

  assign released = rel_q;

  p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(rel_q) |-> $past(tick));
  p_release_needs_sync_r8: assert property (@(posedge clk) disable iff (!supply_ok)
    rel_q |-> good);
endmodule

// File: rtl/boot_fetch_fsm.sv
module boot_fetch_fsm
  import por_boot_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter logic [AW-1:0] SP_ADDR = '0,
  parameter logic [AW-1:0] PC_ADDR = AW'(4)
) (
  input  logic          clk,
  input  logic          supply_ok,
  input  logic          tick,
  input  logic          start,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] pc,
  output logic          done
);
  boot_state_e   st_q;
  logic          req_q;
  logic          done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] sp_q;
  logic [DW-1:0] pc_q;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      st_q   <= BS_IDLE;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
    end else if (tick) begin
      case (st_q)
        BS_IDLE: if (start) begin
          st_q   <= BS_SP;
          req_q  <= 1'b1;
          addr_q <= SP_ADDR;
        end
        BS_SP: if (mem_ready) begin
          sp_q   <= mem_rdata;
          addr_q <= PC_ADDR;
          st_q   <= BS_PC;
        end
        BS_PC: if (mem_ready) begin
          pc_q   <= mem_rdata;
          req_q  <= 1'b0;
          done_q <= 1'b1;
          st_q   <= BS_DONE;
        end
        default: ;
      endcase
    end
  end

  assign req  = req_q;
  assign addr = addr_q;
  assign sp   = sp_q;
  assign pc   = pc_q;
  assign done = done_q;

  p_hold_while_stalled_r6: assert property (@(posedge clk) disable iff (!supply_ok)
    (req_q && !(tick && mem_ready)) |=> (req_q && $stable(addr_q)));
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!supply_ok)
    done_q |=> (done_q && !req_q));
endmodule

// File: rtl/por_boot_seq.sv
module por_boot_seq #(
  parameter int DIV          = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_TICKS = 4,
  parameter int AW           = 32,
  parameter int DW           = 32
) (
  input  logic          osc_clk,
  input  logic          supply_ok,
  output logic          sys_clk_o,
  output logic          por_n_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] pc_o,
  output logic          boot_done_o
);
  localparam logic [AW-1:0] SP_ADDR = '0;
  localparam logic [AW-1:0] PC_ADDR = AW'(DW / 8);

  logic tick;
  logic start;

  por_clk_div #(.DIV(DIV)) u_div (
    .clk     (osc_clk),
    .sys_clk (sys_clk_o),
    .tick    (tick)
  );

  por_release_filter #(
    .SYNC_STAGES  (SYNC_STAGES),
    .STABLE_TICKS (STABLE_TICKS)
  ) u_filt (
    .clk       (osc_clk),
    .supply_ok (supply_ok),
    .tick      (tick),
    .released  (por_n_o),
    .start     (start)
  );

  boot_fetch_fsm #(
    .AW      (AW),
    .DW      (DW),
    .SP_ADDR (SP_ADDR),
    .PC_ADDR (PC_ADDR)
  ) u_fetch (
    .clk       (osc_clk),
    .supply_ok (supply_ok),
    .tick      (tick),
    .start     (start),
    .mem_ready (mem_ready_i),
    .mem_rdata (mem_rdata_i),
    .req       (mem_req_o),
    .addr      (mem_addr_o),
    .sp        (sp_o),
    .pc        (pc_o),
    .done      (boot_done_o)
  );

  p_hold_reset_r1: assert property (@(posedge osc_clk)
    !supply_ok |-> (!por_n_o && !mem_req_o && !boot_done_o));
  p_req_after_release_r4: assert property (@(posedge osc_clk) disable iff (!supply_ok)
    mem_req_o |-> por_n_o);
  p_done_after_release_r5: assert property (@(posedge osc_clk) disable iff (!supply_ok)
    boot_done_o |-> por_n_o);
endmodule

// File: tb/tb_por_boot_seq.sv
`timescale 1ns/1ps
module tb_por_boot_seq;
  logic        clk = 1'b0;
  logic        sup = 1'b0;
  logic        rdy = 1'b0;
  logic [31:0] w_sp = 32'h2000_1000;
  logic [31:0] w_pc = 32'h0000_0101;
  logic        sys_clk, por_n, req, done;
  logic [31:0] addr, rdata, sp, pc;

  always #2 clk = ~clk;

  assign rdata = (addr == 32'h0) ? w_sp : w_pc;

  por_boot_seq dut (
    .osc_clk     (clk),
    .supply_ok   (sup),
    .sys_clk_o   (sys_clk),
    .por_n_o     (por_n),
    .mem_req_o   (req),
    .mem_addr_o  (addr),
    .mem_ready_i (rdy),
    .mem_rdata_i (rdata),
    .sp_o        (sp),
    .pc_o        (pc),
    .boot_done_o (done)
  );

  // behavioural reference, advanced on each oscillator edge
  int          ph = 0;
  int          sync_cnt = 0;
  int          stable_cnt = 0;
  int          mst = 0;       // 0 idle, 1 first read, 2 second read, 3 done
  bit          m_por = 0, m_req = 0, m_done = 0;
  logic [31:0] m_addr = 0, m_sp = 0, m_pc = 0;
  int          vectors = 0, miscompares = 0, cycles = 0;
  bit          run = 0;

  always @(posedge clk) begin
    if (!sup) begin
      sync_cnt = 0; stable_cnt = 0; mst = 0;
      m_por = 0; m_req = 0; m_done = 0; m_addr = 0; m_sp = 0; m_pc = 0;
    end else if (ph == 1) begin
      if (mst == 1 && rdy) begin
        m_sp = (m_addr == 0) ? w_sp : w_pc; m_addr = 4; mst = 2;
      end else if (mst == 2 && rdy) begin
        m_pc = (m_addr == 0) ? w_sp : w_pc; m_req = 0; m_done = 1; mst = 3;
      end
      if (!m_por && sync_cnt >= 2) begin
        stable_cnt++;
        if (stable_cnt == 4) begin
          m_por = 1; m_req = 1; m_addr = 0; mst = 1;
        end
      end
      if (sync_cnt < 2) sync_cnt++;
    end
    ph = (ph + 1) % 4;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk("R2 sys_clk", {31'd0, sys_clk}, {31'd0, ph >= 2});
      if (!sup) begin
        chk("R1/R7 por_n", {31'd0, por_n}, 32'd0);
        chk("R1/R7 req", {31'd0, req}, 32'd0);
        chk("R1/R7 done", {31'd0, done}, 32'd0);
        chk("R1/R7 addr", addr, 32'd0);
        chk("R1/R7 sp", sp, 32'd0);
        chk("R1/R7 pc", pc, 32'd0);
      end else begin
        chk("R3/R8 por_n", {31'd0, por_n}, {31'd0, m_por});
        chk("R4/R6 req", {31'd0, req}, {31'd0, m_req});
        chk("R4/R6 addr", addr, m_addr);
        chk("R5 sp", sp, m_sp);
        chk("R5/R9 pc", pc, m_pc);
        chk("R5/R9 done", {31'd0, done}, {31'd0, m_done});
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    run = 1;
    // R1: held in reset with supply low, clock still running (R2)
    step(40);
    // R3, R4, R5: clean power-up, memory always ready
    sup = 1; rdy = 1;
    step(120);
    // R7: drop after boot, then restart with a stalling memory (R6)
    sup = 0;
    step(10);
    w_sp = 32'h2000_7FF0; w_pc = 32'h0000_0A01;
    sup = 1;
    for (int i = 0; i < 400; i++) begin
      rdy = ($urandom % 4) == 0;
      step(1);
    end
    rdy = 1;
    step(40);
    // R8: short pulse ending inside the stability window
    sup = 0; step(9);
    sup = 1; step(14);
    sup = 0; step(3);
    w_sp = 32'h1FFF_FFFC; w_pc = 32'h0000_4001;
    sup = 1; rdy = 0;
    // R9: stall the second read, then drop supply in the cycle it completes
    for (int i = 0; i < 200 && !(mst == 1); i++) step(1);
    rdy = 1; step(4);
    rdy = 0;
    for (int i = 0; i < 200 && !(mst == 2); i++) step(1);
    step(12);
    for (int i = 0; i < 8 && ph != 1; i++) step(1);
    rdy = 1; sup = 0;
    step(8);
    // R7 again: recover and complete
    sup = 1;
    step(100);
    run = 0;
    step(1);
    finish_run();
  end
endmodule